// File: doc/BRIEF.md
# Prescaled Periodic Interval Timer

This block is a single periodic down-counting timer controlled through a two-word register port: one control word and one status word. Software writes a 9-bit reload value and a handful of mode bits into the control word. Once enabled, the timer counts down from the reload value and wraps back to it.

Each period is the reload value plus one ticks long. A tick is either every clock or, when the prescale bit is set, every `PRESCALE` clocks. `PRESCALE` is a parameter: 20480 for a normal clock tree, 4096 when the PLL is bypassed.

Each time the count wraps, a sticky pending flag is set. Software clears the flag by writing a one to its status bit. When the interrupt enable is on, the pending flag drives exactly one of two interrupt lines, normal or fast, as chosen by a control bit. Several copies can sit side by side, one per timer.

Top module: `interval_timer`

## Requirements
- R1: After reset, both register words read 0, and `irq_o` and `fiq_o` are 0.
- R2: Control word fields are: bit 31 enable, bit 30 interrupt enable, bit 29 fast-line select, bit 28 prescale select, bits 8:0 reload value. These bits read back as written, and all other control bits read 0.
- R3: The count loads the reload value on the first clock after the enable bit goes from 0 to 1. Without prescale, the first pending flag is set on the (reload+2)th clock after the enabling write.
- R4: Without prescale, the pending flag is set once every reload+1 clocks. The count goes through reload..0 and then reloads. This holds for a reload of 0 as well, which gives a period of one clock.
- R5: With bit 28 set, the counter advances once every `PRESCALE` clocks, so the period is (reload+1)·`PRESCALE` clocks.
- R6: Status bit 30 shows the pending flag, and status bits 8:0 show the current count. All other status bits read 0. Writing a status word with bit 30 = 1 clears the flag, and a write with bit 30 = 0 leaves it set. A new set in the same clock as a clear takes priority.
- R7: `irq_o` equals pending AND interrupt enable AND NOT fast-select. `fiq_o` equals pending AND interrupt enable AND fast-select.
- R8: While the enable bit is 0, the count holds its value, the prescaler is held at zero, and the pending flag is never set. Enabling the timer again restarts the count from the reload value.
- R9: The maximum reload value, 0x1FF, gives a period of 512 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the selected word |
| reg_sel | input | 1 | Word select: 0 control, 1 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word (combinational) |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
A wrong reload or a wrong decrement shows up as a period that differs from reload+1 ticks. This is measured between two consecutive sets of the pending flag, so it is caught within one period. A prescaler that is off by one stretches or shrinks every prescaled period by reload+1 clocks. An enable edge that is missed, or a count that keeps moving while disabled, is visible on the status count field one clock later. A wrong route of the pending flag shows up at once on the interrupt pins.

// File: rtl/tmr_pkg.sv
// Shared encodings for the interval timer: word select and control bit positions.
// Assumes a 32-bit register word.
package tmr_pkg;
    localparam int WORD_W   = 32;
    localparam int BIT_EN   = 31;
    localparam int BIT_IE   = 30;
    localparam int BIT_FAST = 29;
    localparam int BIT_PRE  = 28;
    localparam int BIT_PEND = 30;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_STAT = 1'b1
    } word_sel_e;
endpackage

// File: rtl/tmr_prescaler.sv
// Divides the clock by PRESCALE and emits a one-cycle tick.
// Assumes PRESCALE >= 2. The count is held at zero while en_i is low.
module tmr_prescaler #(
    parameter int PRESCALE = 20480
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int PW = $clog2(PRESCALE + 1);
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] pc_q;

    assign tick_o = en_i && (pc_q == LAST);

    // Advance the divider while enabled, wrap at the last step, otherwise hold zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) pc_q <= '0;
        else if (tick_o)     pc_q <= '0;
        else                 pc_q <= pc_q + 1'b1;
    end

    assert_pc_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pc_q <= LAST);
    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> pc_q == '0);
endmodule

// File: rtl/tmr_counter.sv
// Down counter with reload and a sticky pending flag.
// Assumes load_i and step_i come from the control logic; load_i has priority.
module tmr_counter #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             pend_o
);
    logic [CNT_W-1:0] count_q;
    logic             pend_q;
    logic             wrap;

    assign wrap    = step_i && !load_i && (count_q == '0);
    assign count_o = count_q;
    assign pend_o  = pend_q;

    // Load on enable, reload on wrap, otherwise decrement on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)      count_q <= '0;
        else if (load_i) count_q <= reload_i;
        else if (wrap)   count_q <= reload_i;
        else if (step_i) count_q <= count_q - 1'b1;
    end

    // A wrap sets the flag; a software clear drops it unless a wrap coincides.
    always_ff @(posedge clk) begin
        if (!rst_n)     pend_q <= 1'b0;
        else if (wrap)  pend_q <= 1'b1;
        else if (clr_i) pend_q <= 1'b0;
    end

    assert_set_from_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(count_q) == '0);
    assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !step_i) |=> !pend_q);
endmodule

// File: rtl/tmr_irq_route.sv
// Steers the gated pending flag to the normal or the fast interrupt line.
// Assumes all inputs are registered state.
module tmr_irq_route (
    input  logic pend_i,
    input  logic ie_i,
    input  logic fast_i,
    output logic irq_o,
    output logic fiq_o
);
    logic live;

    // Gate by enable, then pick exactly one line.
    always_comb begin
        live  = pend_i && ie_i;
        irq_o = live && !fast_i;
        fiq_o = live && fast_i;
    end

    always_comb begin
        assert_one_line_R7: assert (!(irq_o && fiq_o));
    end
endmodule

// File: rtl/interval_timer.sv
// Register-programmed periodic timer: control and status words, optional
// prescaled tick, and interrupt routing. Assumes PRESCALE >= 2.
module interval_timer #(
    parameter int PRESCALE = 20480,
    parameter int CNT_W    = 9
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq_o,
    output logic        fiq_o
);
    import tmr_pkg::*;

    logic             en_q, ie_q, fast_q, pre_q, run_q;
    logic [CNT_W-1:0] reload_q;
    logic             wr_ctrl, wr_stat, load, step, ptick, pend;
    logic [CNT_W-1:0] count;
    logic             unused_wdata;

    assign wr_ctrl      = reg_wr && (word_sel_e'(reg_sel) == SEL_CTRL);
    assign wr_stat      = reg_wr && (word_sel_e'(reg_sel) == SEL_STAT);
    assign unused_wdata = ^reg_wdata[27:CNT_W];

    // Capture the control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0; ie_q <= 1'b0; fast_q <= 1'b0; pre_q <= 1'b0;
            reload_q <= '0;
        end else if (wr_ctrl) begin
            en_q     <= reg_wdata[BIT_EN];
            ie_q     <= reg_wdata[BIT_IE];
            fast_q   <= reg_wdata[BIT_FAST];
            pre_q    <= reg_wdata[BIT_PRE];
            reload_q <= reg_wdata[CNT_W-1:0];
        end
    end

    // Delayed enable, used to find the enable edge.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= en_q;
    end

    assign load = en_q && !run_q;
    assign step = en_q && (pre_q ? ptick : 1'b1);

    tmr_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n), .en_i(en_q && pre_q), .tick_o(ptick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step),
        .clr_i(wr_stat && reg_wdata[BIT_PEND]), .reload_i(reload_q),
        .count_o(count), .pend_o(pend)
    );

    tmr_irq_route u_route (
        .pend_i(pend), .ie_i(ie_q), .fast_i(fast_q), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    // Read mux for the two words.
    always_comb begin
        reg_rdata = '0;
        if (word_sel_e'(reg_sel) == SEL_CTRL) begin
            reg_rdata[BIT_EN]      = en_q;
            reg_rdata[BIT_IE]      = ie_q;
            reg_rdata[BIT_FAST]    = fast_q;
            reg_rdata[BIT_PRE]     = pre_q;
            reg_rdata[CNT_W-1:0]   = reload_q;
        end else begin
            reg_rdata[BIT_PEND]    = pend;
            reg_rdata[CNT_W-1:0]   = count;
        end
    end

    assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> $stable(count));
    assert_tick_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ptick |=> !ptick);
    assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || fiq_o) |-> (pend && ie_q));
    assert_load_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_q) |=> count == $past(reload_q));
endmodule

// File: tb/interval_timer_test.sv
module interval_timer_test;
    localparam int CLK_NS = 10;
    localparam int PRE    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b1;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o, fiq_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    localparam logic [31:0] EN = 32'h8000_0000, IE = 32'h4000_0000,
                            FAST = 32'h2000_0000, PSC = 32'h1000_0000,
                            PEND = 32'h4000_0000;

    interval_timer #(.PRESCALE(PRE), .CNT_W(9)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        #1 reg_wr = 1'b0; reg_sel = 1'b1;
    endtask

    task automatic rd(input logic sel, output logic [31:0] d);
        reg_sel = sel;
        #1 d = reg_rdata;
        reg_sel = 1'b1;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic quiesce();
        wr(1'b0, 32'h0);
        wr(1'b1, PEND);
    endtask

    // Measures the clocks between two consecutive sets of the pending flag.
    task automatic measure(input string req, input logic [31:0] ctrl, input int exp);
        logic [31:0] s;
        int n = 0;
        quiesce();
        wr(1'b0, ctrl);
        rd(1'b1, s);
        while (!s[30] && n < 20000) begin step(1); rd(1'b1, s); n++; end
        wr(1'b1, PEND);
        n = 1;
        rd(1'b1, s);
        while (!s[30] && n < 20000) begin step(1); rd(1'b1, s); n++; end
        check(req, n, exp);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(1'b0, d); check("R1 ctrl", d, 0);
        rd(1'b1, d); check("R1 status", d, 0);
        check("R1 irq/fiq", {irq_o, fiq_o}, 0);
    endtask

    task automatic t_readback();
        logic [31:0] d;
        wr(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, d); check("R2 all ones", d, 32'hF000_01FF);
        wr(1'b0, 32'h5000_00A5);
        rd(1'b0, d); check("R2 pattern", d, 32'h5000_00A5);
        quiesce();
        rd(1'b1, d); check("R6 status zero bits", d & 32'hBFFF_FE00, 0);
    endtask

    task automatic t_start();
        logic [31:0] d;
        quiesce();
        wr(1'b0, EN | 32'd5);
        step(1); rd(1'b1, d); check("R3 load on enable", d, 32'd5);
        step(5); rd(1'b1, d); check("R3 before first set", d, 32'd0);
        step(1); rd(1'b1, d); check("R3 first set and reload", d, PEND | 32'd5);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        quiesce();
        wr(1'b0, EN);
        step(3);
        wr(1'b0, 32'h0);
        rd(1'b1, d); check("R6 pending held", d[30], 1);
        wr(1'b1, 32'h0);
        rd(1'b1, d); check("R6 write 0 ignored", d[30], 1);
        wr(1'b1, PEND);
        rd(1'b1, d); check("R6 write 1 clears", d[30], 0);
    endtask

    task automatic t_route();
        logic [31:0] d;
        quiesce();
        wr(1'b0, EN);
        step(3);
        wr(1'b0, IE);
        check("R7 normal line", {irq_o, fiq_o}, 2'b10);
        wr(1'b0, IE | FAST);
        check("R7 fast line", {irq_o, fiq_o}, 2'b01);
        wr(1'b0, FAST);
        rd(1'b1, d);
        check("R7 gated off", {d[30], irq_o, fiq_o}, 3'b100);
        quiesce();
        wr(1'b0, IE);
        check("R7 no pending", {irq_o, fiq_o}, 2'b00);
    endtask

    task automatic t_freeze();
        logic [31:0] a, b;
        quiesce();
        wr(1'b0, EN | 32'd20);
        step(5);
        wr(1'b0, 32'd20);
        rd(1'b1, a);
        step(30);
        rd(1'b1, b);
        check("R8 frozen count", b, a);
        check("R8 no pending", b[30], 0);
        wr(1'b0, EN | 32'd20);
        step(1); rd(1'b1, b);
        check("R8 reload on re-enable", b[8:0], 20);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_readback();
        t_start();
        measure("R4 period reload 3", EN | 32'd3, 4);
        measure("R4 period reload 0", EN, 1);
        measure("R5 prescaled period", EN | PSC | 32'd2, 3 * PRE);
        measure("R9 max reload", EN | 32'h1FF, 512);
        t_clear();
        t_route();
        t_freeze();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL R1 watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule